// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits on the address path of one bus master and maps each request into the target slave space. The 4 GB space is cut into sixteen 256 MB apertures, and the top address nibble picks one of them. Each aperture has two programmable 4-bit fields. The first names the target slave. The second is the aperture number that replaces the top nibble in the outgoing address. The lower 28 bits pass through unchanged. A slave field of zero marks an aperture as unmapped. A request that lands there is flagged as a decode error and drives no slave.

Software programs the mapping through a plain register port that writes a shadow copy. The new mapping takes effect only when a write to the commit register has bit 0 set. Until then, requests keep using the last committed mapping, so the map can be rebuilt field by field without ever routing traffic through a half-written state.

The request and response sides use valid/ready handshakes with one register stage between them. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high whenever the output stage is empty or its contents are being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.

Top module: `aperture_remap`

## Requirements
- R1: After reset, every aperture is unmapped in both the shadow and the committed map: all five register words read zero, `rsp_valid` is low, and any request returns a decode error.
- R2: Address bits [31:28] select the aperture. The response address is the aperture's target field in bits [31:28], followed by request bits [27:0] unchanged.
- R3: A request to an aperture whose slave field is 0 gives `rsp_decerr`=1 and `rsp_slave`=0. Any other slave field gives `rsp_decerr`=0 and `rsp_slave` equal to that field.
- R4: Fields are packed eight to a 32-bit word, with aperture i placed at bits [4(i mod 8)+3:4(i mod 8)]. The words sit at these byte offsets:
  - 0x0: slave fields for apertures 0-7
  - 0x4: slave fields for apertures 8-15
  - 0x8: target fields for apertures 0-7
  - 0xC: target fields for apertures 8-15
- R5: Shadow writes leave translation unchanged. A write to offset 0x10 with bit 0 = 1 copies the shadow map into the committed map on that clock edge. A write to 0x10 with bit 0 = 0 does nothing.
- R6: `cfg_rdata` shows the shadow word at `cfg_addr` in the same cycle. Offset 0x10 and offsets 0x14-0x1C always read zero, and writes to 0x14-0x1C change nothing.
- R7: A request accepted at a clock edge appears on the response outputs after that edge, with `rsp_valid` high. `rsp_valid` falls after the response is taken if no new request was accepted.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is low and all response outputs hold steady. When `rsp_ready`=1, a new request can be accepted in the same cycle.
- R9: `rsp_decerr` is never high while `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Translated result valid |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_addr | output | 32 | Translated address |
| rsp_slave | output | 4 | Target slave index, 0 when unmapped |
| rsp_decerr | output | 1 | Request hit an unmapped aperture |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Shadow register read data |

## Verification
All sixteen apertures are swept under two different committed maps. Each sweep uses three low-address patterns: all zeros, all ones and an alternating pattern. This separates the aperture-select path from the pass-through of the low 28 bits, and it exposes a slice of the packed field word that is misplaced. Both maps contain unmapped apertures at known indices, which tests the decode-error path against slave fields that neighbour it. Writes to the shadow registers, a commit write with bit 0 clear, and writes to the unused words are each followed by a full sweep. Those sweeps show that the committed map changes only on a true commit. A stalled response, with the request address changed underneath it, checks that the output register holds, and the release of the stall checks acceptance in the same cycle.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    CW_SLAVE  = 2'd0,
    CW_TARGET = 2'd1,
    CW_COMMIT = 2'd2,
    CW_NONE   = 2'd3
  } cfg_kind_e;

  // Classifies a register word index given the number of words per field table.
  function automatic cfg_kind_e word_kind(input int word, input int nreg);
    if (word < nreg)             return CW_SLAVE;
    else if (word < 2 * nreg)    return CW_TARGET;
    else if (word == 2 * nreg)   return CW_COMMIT;
    else                         return CW_NONE;
  endfunction
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int FLD_W  = 4,
  parameter int REG_W  = 32,
  parameter int CFG_AW = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [REG_W-1:0]            cfg_wdata,
  output logic [REG_W-1:0]            cfg_rdata,
  output logic [(2**FLD_W)*FLD_W-1:0] act_slave,
  output logic [(2**FLD_W)*FLD_W-1:0] act_target
);
  localparam int NUM_AP = 2 ** FLD_W;
  localparam int MAP_W  = NUM_AP * FLD_W;
  localparam int NREG   = MAP_W / REG_W;
  localparam int WORD_W = CFG_AW - 2;

  logic [MAP_W-1:0]  sh_slave, sh_target;
  logic [WORD_W-1:0] word;
  cfg_kind_e         kind;
  logic              commit;

  assign word   = cfg_addr[CFG_AW-1:2];
  assign kind   = word_kind(int'(word), NREG);
  assign commit = cfg_we && (kind == CW_COMMIT) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_slave  <= '0;
      sh_target <= '0;
    end else if (cfg_we) begin
      for (int r = 0; r < NREG; r++) begin
        if (word == WORD_W'(r))
          sh_slave[r*REG_W +: REG_W] <= cfg_wdata;
        if (word == WORD_W'(NREG + r))
          sh_target[r*REG_W +: REG_W] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_slave  <= '0;
      act_target <= '0;
    end else if (commit) begin
      act_slave  <= sh_slave;
      act_target <= sh_target;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (word == WORD_W'(r))
        cfg_rdata = sh_slave[r*REG_W +: REG_W];
      if (word == WORD_W'(NREG + r))
        cfg_rdata = sh_target[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup #(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 4
) (
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic [(2**FLD_W)*FLD_W-1:0] act_slave,
  input  logic [(2**FLD_W)*FLD_W-1:0] act_target,
  output logic [ADDR_W-1:0]           addr_out,
  output logic [FLD_W-1:0]            slave,
  output logic                        decerr
);
  localparam int NUM_AP = 2 ** FLD_W;
  localparam int LOW_W  = ADDR_W - FLD_W;

  logic [FLD_W-1:0] ap;
  logic [FLD_W-1:0] slave_tab  [NUM_AP];
  logic [FLD_W-1:0] target_tab [NUM_AP];

  assign ap = addr_in[ADDR_W-1 -: FLD_W];

  for (genvar i = 0; i < NUM_AP; i++) begin : g_unpack
    assign slave_tab[i]  = act_slave[i*FLD_W +: FLD_W];
    assign target_tab[i] = act_target[i*FLD_W +: FLD_W];
  end

  assign slave    = slave_tab[ap];
  assign decerr   = (slave_tab[ap] == '0);
  assign addr_out = {target_tab[ap], addr_in[LOW_W-1:0]};
endmodule

// File: rtl/remap_stage.sv
module remap_stage #(
  parameter int DATA_W = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 4,
  parameter int REG_W  = 32,
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [FLD_W-1:0]  rsp_slave,
  output logic              rsp_decerr,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata
);
  localparam int MAP_W = (2 ** FLD_W) * FLD_W;
  localparam int PAY_W = ADDR_W + FLD_W + 1;

  logic [MAP_W-1:0]  act_slave, act_target;
  logic [ADDR_W-1:0] lk_addr;
  logic [FLD_W-1:0]  lk_slave;
  logic              lk_decerr;
  logic [PAY_W-1:0]  pay_q;
  logic              stage_valid;

  remap_regs #(.FLD_W(FLD_W), .REG_W(REG_W), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .act_slave(act_slave), .act_target(act_target)
  );

  remap_lookup #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_lookup (
    .addr_in(req_addr), .act_slave(act_slave), .act_target(act_target),
    .addr_out(lk_addr), .slave(lk_slave), .decerr(lk_decerr)
  );

  remap_stage #(.DATA_W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_data({lk_addr, lk_slave, lk_decerr}),
    .out_valid(stage_valid), .out_ready(rsp_ready), .out_data(pay_q)
  );

  assign rsp_valid  = stage_valid;
  assign rsp_addr   = pay_q[PAY_W-1 -: ADDR_W];
  assign rsp_slave  = pay_q[FLD_W:1];
  assign rsp_decerr = pay_q[0] && stage_valid;
endmodule

// File: rtl/aperture_remap_checker.sv
module aperture_remap_checker #(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 4,
  parameter int REG_W  = 32,
  parameter int CFG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [FLD_W-1:0]  rsp_slave,
  input logic              rsp_decerr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [REG_W-1:0]  cfg_rdata
);
  localparam int LOW_W    = ADDR_W - FLD_W;
  localparam int NREG     = (2 ** FLD_W) * FLD_W / REG_W;
  localparam int COMMIT_W = 2 * NREG;

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])); // R2

  AST_DECERR_NO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_decerr |-> rsp_slave == '0); // R3

  AST_COMMIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_addr[CFG_AW-1:2]) == COMMIT_W |-> cfg_rdata == '0); // R6

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_slave)
      && $stable(rsp_decerr)); // R8

  AST_DECERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_decerr); // R9
endmodule

bind aperture_remap aperture_remap_checker #(
  .ADDR_W(ADDR_W), .FLD_W(FLD_W), .REG_W(REG_W), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_slave(rsp_slave), .rsp_decerr(rsp_decerr),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/aperture_remap_test.sv
module aperture_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1, cfg_we = 1'b0;
  logic        req_ready, rsp_valid, rsp_decerr;
  logic [31:0] req_addr = '0, rsp_addr, cfg_wdata = '0, cfg_rdata;
  logic [3:0]  rsp_slave;
  logic [4:0]  cfg_addr = '0;

  int tests = 0, fails = 0;
  int sh_sel [16], sh_off [16], ac_sel [16], ac_off [16];

  always #2 clk = ~clk;

  aperture_remap uut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int t[16], input int base);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(t[base + k]);
    return w;
  endfunction

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    if (a == 5'h10 && d[0]) begin
      ac_sel = sh_sel; ac_off = sh_off;
    end
  endtask

  task automatic cfg_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_addr = a; #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic write_shadow();
    cfg_write(5'h00, pack(sh_sel, 0)); cfg_write(5'h04, pack(sh_sel, 8));
    cfg_write(5'h08, pack(sh_off, 0)); cfg_write(5'h0C, pack(sh_off, 8));
  endtask

  task automatic translate(input logic [31:0] a, input string tag);
    logic [31:0] ea;
    int ap;
    ap = int'(a[31:28]);
    ea = {4'(ac_off[ap]), a[27:0]};
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R7 valid"}, rsp_valid, 1);
    check(rsp_addr == ea, {tag, " R2 addr"}, rsp_addr, ea);
    check(rsp_slave == 4'(ac_sel[ap]), {tag, " R3 slave"}, rsp_slave, ac_sel[ap]);
    check(rsp_decerr == (ac_sel[ap] == 0), {tag, " R3 decerr"}, rsp_decerr, ac_sel[ap] == 0);
  endtask

  task automatic sweep(input string tag);
    for (int ap = 0; ap < 16; ap++) begin
      translate({4'(ap), 28'h0000000}, tag);
      translate({4'(ap), 28'hFFFFFFF}, tag);
      translate({4'(ap), 28'hA5A5A5A}, tag);
    end
    @(negedge clk);
    check(!rsp_valid && !rsp_decerr, {tag, " R7 R9 idle"}, {rsp_valid, rsp_decerr}, 0);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sh_sel[i] = 0; sh_off[i] = 0; ac_sel[i] = 0; ac_off[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!rsp_valid && req_ready, "R1 reset handshake", {rsp_valid, req_ready}, 1);
    for (int w = 0; w < 8; w++) cfg_read(5'(4*w), 32'h0, "R1 R6 reset read");
    sweep("R1 reset map");

    // map A: unmapped where index divisible by 3
    for (int i = 0; i < 16; i++) begin
      sh_sel[i] = (i % 3 == 0) ? 0 : ((i * 7) & 15);
      sh_off[i] = 15 - i;
    end
    write_shadow();
    cfg_read(5'h00, pack(sh_sel, 0), "R4 R6 slave lo");
    cfg_read(5'h04, pack(sh_sel, 8), "R4 R6 slave hi");
    cfg_read(5'h08, pack(sh_off, 0), "R4 R6 target lo");
    cfg_read(5'h0C, pack(sh_off, 8), "R4 R6 target hi");
    sweep("R5 before commit");
    cfg_write(5'h10, 32'hFFFF_FFFE);
    cfg_read(5'h10, 32'h0, "R6 commit reads zero");
    sweep("R5 commit bit clear");
    cfg_write(5'h10, 32'h1);
    sweep("R4 map A");

    // map B: shadow differs from active until commit
    for (int i = 0; i < 16; i++) begin
      sh_sel[i] = (i * 3 + 1) & 15;
      sh_off[i] = (i * 9 + 2) & 15;
    end
    write_shadow();
    sweep("R5 map A kept");
    cfg_write(5'h10, 32'h1);
    sweep("R4 map B");

    // unused words
    cfg_write(5'h14, 32'hFFFF_FFFF);
    cfg_write(5'h18, 32'hFFFF_FFFF);
    cfg_write(5'h1C, 32'hFFFF_FFFF);
    cfg_read(5'h14, 32'h0, "R6 unused read");
    cfg_read(5'h1C, 32'h0, "R6 unused read");
    cfg_read(5'h00, pack(sh_sel, 0), "R6 unused write");
    cfg_write(5'h10, 32'h1);
    sweep("R6 after unused writes");

    // back-pressure
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h3123_4567;
    @(negedge clk); req_addr = 32'h9876_5432;
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid && !req_ready, "R8 stall ready", {rsp_valid, req_ready}, 2);
      check(rsp_addr == {4'(ac_off[3]), 28'h1234567}, "R8 stall hold", rsp_addr,
            {4'(ac_off[3]), 28'h1234567});
      @(negedge clk);
    end
    rsp_ready = 1'b1; #1;
    check(req_ready, "R8 ready same cycle", req_ready, 1);
    @(negedge clk); req_valid = 1'b0;
    check(rsp_valid && rsp_addr == {4'(ac_off[9]), 28'h8765432}, "R8 next accepted",
          rsp_addr, {4'(ac_off[9]), 28'h8765432});
    check(rsp_slave == 4'(ac_sel[9]), "R3 next slave", rsp_slave, ac_sel[9]);
    @(negedge clk);
    check(!rsp_valid && !rsp_decerr, "R7 R9 drained", {rsp_valid, rsp_decerr}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule